// File: doc/BRIEF.md
# Programmable SPI Pin Matrix

This block sits between two octal-capable SPI controllers and a set of external pin ports. Each port carries a clock and inverted clock, a data strobe, a chip select and eight data lines handled as two 4-bit nibbles. Software chooses, for every signal group of every port, which controller signal group drives it and whether the group is driven at all. Data nibbles can be swapped inside a port or taken from the other controller, so any controller nibble can land on any port nibble.

The matrix routes controller outputs and output enables toward the pins, and routes pin inputs (data and strobe) back to the controller that owns them. When time-multiplexing is switched on, every source code that names controller 1 refers instead to a shared multiplexed bus, which an external arbiter produces. Codes that name controller 2 then select nothing. The chip select is never multiplexed and always follows its own controller. Configuration is held in registers behind a simple write/read interface, and writes are honoured only while both controllers report that they are idle.

Top module: `pinmx`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0. The register of port p sits at offset 4*(p+1). Even-numbered ports reset to 0x03010111 (controller 1, nibbles in natural order) and odd-numbered ports reset to 0x07050333 (controller 2, natural order). All groups are enabled at reset.
- R2: Port register fields are as follows. Clock enable is bit 0 and clock source is bit 1. Strobe enable is bit 4 and strobe source is bit 5. Chip-select enable is bit 8 and chip-select source is bit 9. Low-nibble enable is bit 16 with its source in bits 18:17. High-nibble enable is bit 24 with its source in bits 26:25. The control register holds the multiplex enable in bit 0 and an 8-bit switch time in bits 23:16. All other bits read as zero, so an all-ones write reads back 0x07070333 for a port and 0x00FF0001 for control.
- R3: A nibble source code s selects controller lane bits [4s+3:4s] of the 16-bit vector {controller 2 IO, controller 1 IO]: 0 is controller 1 low, 1 is controller 1 high, 2 is controller 2 low and 3 is controller 2 high. The pin nibble and its per-bit output enables copy the selected nibble.
- R4: The clock/inverted-clock pair, the strobe and the chip select each take a 1-bit source, where 0 means controller 1 and 1 means controller 2. An enabled clock pair drives its output enable high. The strobe output enable copies the source strobe enable.
- R5: A disabled group drives its pin outputs and output enables to 0, and the controller input it would feed reads 0.
- R6: A controller data nibble or strobe input reads the pin value of the lowest-numbered port whose enabled group selects it. Within one port, the low nibble wins over the high nibble. Several enabled groups may select the same source, and each of them drives it.
- R7: When multiplexing is enabled, source codes that name controller 1 take the shared bus, and codes that name controller 2 drive 0 with the output enable low. Returned inputs then go to the shared-bus inputs, and both controllers' inputs read 0. When multiplexing is off, the shared-bus inputs read 0.
- R8: The chip select follows its per-controller source whether multiplexing is on or off.
- R9: A write made while any controller-active bit is set leaves every register unchanged and sets the error flag. The error flag stays set until reset.
- R10: Pin outputs and returned controller inputs are registered, so they change one clock after their inputs change. Read data appears one clock after the address is presented. Writes to unmapped offsets are ignored, and reads from unmapped offsets return 0.
- R11: The multiplex enable and the switch time are presented on outputs for the arbiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after the address |
| cfg_err | output | 1 | Sticky flag for a blocked write |
| ctl_active | input | 2 | Per-controller enabled indication |
| mux_en_o | output | 1 | Multiplex enable toward the arbiter |
| sw_time_o | output | 8 | Switch time toward the arbiter |
| ctl_clk | input | 2 | Controller clocks |
| ctl_nclk | input | 2 | Controller inverted clocks |
| ctl_ncs | input | 2 | Controller chip selects |
| ctl_dqs_o | input | 2 | Controller strobe outputs |
| ctl_dqs_oe | input | 2 | Controller strobe output enables |
| ctl_io_o | input | 4*NIB_W | Controller data outputs {ctrl2, ctrl1} |
| ctl_io_oe | input | 4*NIB_W | Controller data output enables |
| ctl_dqs_i | output | 2 | Strobe returned to each controller |
| ctl_io_i | output | 4*NIB_W | Data returned to each controller |
| mx_clk | input | 1 | Shared bus clock |
| mx_nclk | input | 1 | Shared bus inverted clock |
| mx_dqs_o | input | 1 | Shared bus strobe output |
| mx_dqs_oe | input | 1 | Shared bus strobe output enable |
| mx_io_o | input | 2*NIB_W | Shared bus data outputs |
| mx_io_oe | input | 2*NIB_W | Shared bus data output enables |
| mx_dqs_i | output | 1 | Strobe returned to the shared bus |
| mx_io_i | output | 2*NIB_W | Data returned to the shared bus |
| pin_clk | output | NUM_PORTS | Port clocks |
| pin_nclk | output | NUM_PORTS | Port inverted clocks |
| pin_clk_oe | output | NUM_PORTS | Port clock output enables |
| pin_dqs_o | output | NUM_PORTS | Port strobe outputs |
| pin_dqs_oe | output | NUM_PORTS | Port strobe output enables |
| pin_dqs_i | input | NUM_PORTS | Port strobe inputs |
| pin_ncs | output | NUM_PORTS | Port chip selects |
| pin_ncs_oe | output | NUM_PORTS | Port chip select output enables |
| pin_io_o | output | NUM_PORTS*2*NIB_W | Port data outputs |
| pin_io_oe | output | NUM_PORTS*2*NIB_W | Port data output enables |
| pin_io_i | input | NUM_PORTS*2*NIB_W | Port data inputs |

## Verification
The bench builds the matrix with NUM_PORTS = 3 and NIB_W = 4. With three ports, two of them come out of reset selecting the same controller, so the lowest-port-wins rule on the return path can be checked straight from reset. It also brings a third register offset (0xC) into the address decode. Each controller nibble is given a distinct value, so every source code, every nibble swap and every case of a multiplexed lane being substituted shows up as a unique pin value.

// File: rtl/pinmx_pkg.sv
package pinmx_pkg;

  localparam int REG_W = 32;
  localparam int SWT_W = 8;
  localparam logic [REG_W-1:0] CTRL_MASK = 32'h00FF_0001;
  localparam logic [REG_W-1:0] PORT_MASK = 32'h0707_0333;
  localparam logic [REG_W-1:0] EVEN_RST  = 32'h0301_0111;
  localparam logic [REG_W-1:0] ODD_DELTA = 32'h0404_0222;

  typedef struct packed {
    logic       hi_en;
    logic [1:0] hi_src;
    logic       lo_en;
    logic [1:0] lo_src;
    logic       ncs_en;
    logic       ncs_src;
    logic       dqs_en;
    logic       dqs_src;
    logic       clk_en;
    logic       clk_src;
  } port_cfg_t;

  function automatic port_cfg_t decode_port(input logic [REG_W-1:0] w);
    port_cfg_t c;
    c.clk_en  = w[0];
    c.clk_src = w[1];
    c.dqs_en  = w[4];
    c.dqs_src = w[5];
    c.ncs_en  = w[8];
    c.ncs_src = w[9];
    c.lo_en   = w[16];
    c.lo_src  = w[18:17];
    c.hi_en   = w[24];
    c.hi_src  = w[26:25];
    return c;
  endfunction

  // Even ports default to controller 1, odd ports to controller 2 (R1).
  function automatic logic [REG_W-1:0] port_reset(input int p);
    return (p % 2 == 1) ? (EVEN_RST | ODD_DELTA) : EVEN_RST;
  endfunction

endpackage

// File: rtl/pinmx_regs.sv
module pinmx_regs
  import pinmx_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  input  logic [1:0]                   ctl_active,
  output logic [REG_W-1:0]             reg_rdata,
  output logic                         cfg_err,
  output logic                         mux_en,
  output logic [SWT_W-1:0]             sw_time,
  output port_cfg_t [NUM_PORTS-1:0]    cfg
);

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] port_q [NUM_PORTS];
  logic [REG_W-1:0] rd_sel;
  logic             busy;
  logic             wr_ok;

  assign busy  = |ctl_active;
  assign wr_ok = reg_wr && !busy;

  always_comb begin
    rd_sel = '0;
    if (reg_addr == '0) rd_sel = ctrl_q;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (reg_addr == ADDR_W'(4 * (p + 1))) rd_sel = port_q[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cfg_err   <= 1'b0;
      reg_rdata <= '0;
      for (int p = 0; p < NUM_PORTS; p++) port_q[p] <= port_reset(p);
    end else begin
      reg_rdata <= rd_sel;
      if (reg_wr && busy) cfg_err <= 1'b1;
      if (wr_ok && reg_addr == '0) ctrl_q <= reg_wdata & CTRL_MASK;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wr_ok && reg_addr == ADDR_W'(4 * (p + 1)))
          port_q[p] <= reg_wdata & PORT_MASK;
      end
    end
  end

  assign mux_en  = ctrl_q[0];
  assign sw_time = ctrl_q[16 +: SWT_W];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign cfg[p] = decode_port(port_q[p]);
  end

endmodule

// File: rtl/pinmx_port_out.sv
module pinmx_port_out
  import pinmx_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  port_cfg_t            cfg,
  input  logic                 mux_en,
  input  logic [1:0]           lane_clk,
  input  logic [1:0]           lane_nclk,
  input  logic [1:0]           lane_dqs_o,
  input  logic [1:0]           lane_dqs_oe,
  input  logic [4*NIB_W-1:0]   lane_io_o,
  input  logic [4*NIB_W-1:0]   lane_io_oe,
  input  logic [1:0]           ctl_ncs,
  output logic                 pin_clk,
  output logic                 pin_nclk,
  output logic                 pin_clk_oe,
  output logic                 pin_dqs_o,
  output logic                 pin_dqs_oe,
  output logic                 pin_ncs,
  output logic                 pin_ncs_oe,
  output logic [2*NIB_W-1:0]   pin_io_o,
  output logic [2*NIB_W-1:0]   pin_io_oe
);

  localparam int IO_W = 2 * NIB_W;

  logic            clk_live, dqs_live;
  logic [IO_W-1:0] io_d, oe_d;

  // A controller-2 code names nothing while the bus is multiplexed.
  assign clk_live = cfg.clk_en && !(mux_en && cfg.clk_src);
  assign dqs_live = cfg.dqs_en && !(mux_en && cfg.dqs_src);

  for (genvar h = 0; h < 2; h++) begin : g_nib
    logic       en;
    logic [1:0] src;
    logic       live;
    assign en   = (h == 1) ? cfg.hi_en  : cfg.lo_en;
    assign src  = (h == 1) ? cfg.hi_src : cfg.lo_src;
    assign live = en && !(mux_en && src[1]);
    assign io_d[h*NIB_W +: NIB_W] = live ? lane_io_o[src*NIB_W +: NIB_W]  : '0;
    assign oe_d[h*NIB_W +: NIB_W] = live ? lane_io_oe[src*NIB_W +: NIB_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_clk    <= 1'b0;
      pin_nclk   <= 1'b0;
      pin_clk_oe <= 1'b0;
      pin_dqs_o  <= 1'b0;
      pin_dqs_oe <= 1'b0;
      pin_ncs    <= 1'b0;
      pin_ncs_oe <= 1'b0;
      pin_io_o   <= '0;
      pin_io_oe  <= '0;
    end else begin
      pin_clk    <= clk_live && lane_clk[cfg.clk_src];
      pin_nclk   <= clk_live && lane_nclk[cfg.clk_src];
      pin_clk_oe <= clk_live;
      pin_dqs_o  <= dqs_live && lane_dqs_o[cfg.dqs_src];
      pin_dqs_oe <= dqs_live && lane_dqs_oe[cfg.dqs_src];
      pin_ncs    <= cfg.ncs_en && ctl_ncs[cfg.ncs_src];
      pin_ncs_oe <= cfg.ncs_en;
      pin_io_o   <= io_d;
      pin_io_oe  <= oe_d;
    end
  end

endmodule

// File: rtl/pinmx_return.sv
module pinmx_return
  import pinmx_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NIB_W     = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  port_cfg_t [NUM_PORTS-1:0]       cfg,
  input  logic                            mux_en,
  input  logic [NUM_PORTS*2*NIB_W-1:0]    pin_io_i,
  input  logic [NUM_PORTS-1:0]            pin_dqs_i,
  output logic [4*NIB_W-1:0]              ctl_io_i,
  output logic [1:0]                      ctl_dqs_i,
  output logic [2*NIB_W-1:0]              mx_io_i,
  output logic                            mx_dqs_i
);

  localparam int IO_W = 2 * NIB_W;

  logic [4*NIB_W-1:0] ret_io;
  logic [3:0]         got_io;
  logic [1:0]         ret_dqs;
  logic [1:0]         got_dqs;

  // Ascending scan with first-hit capture: lowest port, then low nibble, wins.
  always_comb begin
    ret_io  = '0;
    got_io  = '0;
    ret_dqs = '0;
    got_dqs = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int h = 0; h < 2; h++) begin
        logic       en;
        logic [1:0] src;
        en  = (h == 1) ? cfg[p].hi_en  : cfg[p].lo_en;
        src = (h == 1) ? cfg[p].hi_src : cfg[p].lo_src;
        if (en && !got_io[src] && !(mux_en && src[1])) begin
          ret_io[src*NIB_W +: NIB_W] = pin_io_i[(p*2 + h)*NIB_W +: NIB_W];
          got_io[src] = 1'b1;
        end
      end
      if (cfg[p].dqs_en && !got_dqs[cfg[p].dqs_src] && !(mux_en && cfg[p].dqs_src)) begin
        ret_dqs[cfg[p].dqs_src] = pin_dqs_i[p];
        got_dqs[cfg[p].dqs_src] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_io_i  <= '0;
      ctl_dqs_i <= '0;
      mx_io_i   <= '0;
      mx_dqs_i  <= 1'b0;
    end else begin
      ctl_io_i  <= mux_en ? '0 : ret_io;
      ctl_dqs_i <= mux_en ? '0 : ret_dqs;
      mx_io_i   <= mux_en ? ret_io[IO_W-1:0] : '0;
      mx_dqs_i  <= mux_en && ret_dqs[0];
    end
  end

endmodule

// File: rtl/pinmx.sv
module pinmx
  import pinmx_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NIB_W     = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  output logic                          cfg_err,
  input  logic [1:0]                    ctl_active,
  output logic                          mux_en_o,
  output logic [7:0]                    sw_time_o,
  input  logic [1:0]                    ctl_clk,
  input  logic [1:0]                    ctl_nclk,
  input  logic [1:0]                    ctl_ncs,
  input  logic [1:0]                    ctl_dqs_o,
  input  logic [1:0]                    ctl_dqs_oe,
  input  logic [4*NIB_W-1:0]            ctl_io_o,
  input  logic [4*NIB_W-1:0]            ctl_io_oe,
  output logic [1:0]                    ctl_dqs_i,
  output logic [4*NIB_W-1:0]            ctl_io_i,
  input  logic                          mx_clk,
  input  logic                          mx_nclk,
  input  logic                          mx_dqs_o,
  input  logic                          mx_dqs_oe,
  input  logic [2*NIB_W-1:0]            mx_io_o,
  input  logic [2*NIB_W-1:0]            mx_io_oe,
  output logic                          mx_dqs_i,
  output logic [2*NIB_W-1:0]            mx_io_i,
  output logic [NUM_PORTS-1:0]          pin_clk,
  output logic [NUM_PORTS-1:0]          pin_nclk,
  output logic [NUM_PORTS-1:0]          pin_clk_oe,
  output logic [NUM_PORTS-1:0]          pin_dqs_o,
  output logic [NUM_PORTS-1:0]          pin_dqs_oe,
  input  logic [NUM_PORTS-1:0]          pin_dqs_i,
  output logic [NUM_PORTS-1:0]          pin_ncs,
  output logic [NUM_PORTS-1:0]          pin_ncs_oe,
  output logic [NUM_PORTS*2*NIB_W-1:0]  pin_io_o,
  output logic [NUM_PORTS*2*NIB_W-1:0]  pin_io_oe,
  input  logic [NUM_PORTS*2*NIB_W-1:0]  pin_io_i
);

  localparam int IO_W = 2 * NIB_W;

  port_cfg_t [NUM_PORTS-1:0] cfg;
  logic                      mux_en;
  logic [1:0]                lane_clk, lane_nclk, lane_dqs_o, lane_dqs_oe;
  logic [2*IO_W-1:0]         lane_io_o, lane_io_oe;

  pinmx_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctl_active(ctl_active), .reg_rdata(reg_rdata),
    .cfg_err(cfg_err), .mux_en(mux_en), .sw_time(sw_time_o), .cfg(cfg)
  );

  assign mux_en_o = mux_en;

  // Lane 0 becomes the shared bus and lane 1 goes dead in multiplexed mode.
  assign lane_clk    = mux_en ? {1'b0, mx_clk}    : ctl_clk;
  assign lane_nclk   = mux_en ? {1'b0, mx_nclk}   : ctl_nclk;
  assign lane_dqs_o  = mux_en ? {1'b0, mx_dqs_o}  : ctl_dqs_o;
  assign lane_dqs_oe = mux_en ? {1'b0, mx_dqs_oe} : ctl_dqs_oe;
  assign lane_io_o   = mux_en ? {{IO_W{1'b0}}, mx_io_o}  : ctl_io_o;
  assign lane_io_oe  = mux_en ? {{IO_W{1'b0}}, mx_io_oe} : ctl_io_oe;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pinmx_port_out #(.NIB_W(NIB_W)) u_out (
      .clk(clk), .rst(rst), .cfg(cfg[p]), .mux_en(mux_en),
      .lane_clk(lane_clk), .lane_nclk(lane_nclk),
      .lane_dqs_o(lane_dqs_o), .lane_dqs_oe(lane_dqs_oe),
      .lane_io_o(lane_io_o), .lane_io_oe(lane_io_oe), .ctl_ncs(ctl_ncs),
      .pin_clk(pin_clk[p]), .pin_nclk(pin_nclk[p]), .pin_clk_oe(pin_clk_oe[p]),
      .pin_dqs_o(pin_dqs_o[p]), .pin_dqs_oe(pin_dqs_oe[p]),
      .pin_ncs(pin_ncs[p]), .pin_ncs_oe(pin_ncs_oe[p]),
      .pin_io_o(pin_io_o[p*IO_W +: IO_W]), .pin_io_oe(pin_io_oe[p*IO_W +: IO_W])
    );
  end

  pinmx_return #(.NUM_PORTS(NUM_PORTS), .NIB_W(NIB_W)) u_ret (
    .clk(clk), .rst(rst), .cfg(cfg), .mux_en(mux_en),
    .pin_io_i(pin_io_i), .pin_dqs_i(pin_dqs_i),
    .ctl_io_i(ctl_io_i), .ctl_dqs_i(ctl_dqs_i),
    .mx_io_i(mx_io_i), .mx_dqs_i(mx_dqs_i)
  );

endmodule

// File: rtl/pinmx_chk.sv
module pinmx_chk #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [1:0]         ctl_active,
  input logic               cfg_err,
  input logic               mux_en_o,
  input logic [7:0]         sw_time_o,
  input logic [4*NIB_W-1:0] ctl_io_i,
  input logic [1:0]         ctl_dqs_i,
  input logic [2*NIB_W-1:0] mx_io_i,
  input logic               mx_dqs_i
);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  assert_blocked_write_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && ctl_active != 2'b00) |=> cfg_err);

  assert_blocked_write_keeps_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && ctl_active != 2'b00) |=> ($stable(mux_en_o) && $stable(sw_time_o)));

  assert_mux_silences_ctl_R7: assert property (@(posedge clk) disable iff (rst)
    $past(mux_en_o) |-> (ctl_io_i == '0 && ctl_dqs_i == 2'b00));

  assert_plain_silences_bus_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(mux_en_o) |-> (mx_io_i == '0 && !mx_dqs_i));

endmodule

bind pinmx pinmx_chk #(.NIB_W(NIB_W)) i_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .ctl_active(ctl_active),
  .cfg_err(cfg_err), .mux_en_o(mux_en_o), .sw_time_o(sw_time_o),
  .ctl_io_i(ctl_io_i), .ctl_dqs_i(ctl_dqs_i), .mx_io_i(mx_io_i), .mx_dqs_i(mx_dqs_i)
);

// File: tb/test_pinmx.sv
module test_pinmx;

  localparam int CLK_PERIOD = 10;
  localparam int NP   = 3;
  localparam int NW   = 4;
  localparam int AW   = 4;
  localparam int NVEC = 8;

  // {port1 word[50:19], mux[18], io[17:10], oe[9:2], clk[1], clk_oe[0]}
  localparam logic [50:0] VEC [NVEC] = '{
    {32'h0701_0001, 1'b0, 8'h41, 8'hFF, 1'b0, 1'b1},
    {32'h0107_0003, 1'b0, 8'h14, 8'hFF, 1'b1, 1'b1},
    {32'h0503_0001, 1'b0, 8'h32, 8'hFF, 1'b0, 1'b1},
    {32'h0205_0000, 1'b0, 8'h03, 8'h0F, 1'b0, 1'b0},
    {32'h0701_0001, 1'b1, 8'h06, 8'h0F, 1'b1, 1'b1},
    {32'h0107_0003, 1'b1, 8'h60, 8'hF0, 1'b0, 1'b0},
    {32'h0503_0001, 1'b1, 8'h09, 8'h0F, 1'b1, 1'b1},
    {32'h0606_0002, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cfg_err, mux_en_o;
  logic [7:0] sw_time_o;
  logic [1:0] ctl_active = 2'b00;
  logic [1:0] ctl_clk = 2'b10, ctl_nclk = 2'b01, ctl_ncs = 2'b10;
  logic [1:0] ctl_dqs_o = 2'b10, ctl_dqs_oe = 2'b11;
  logic [15:0] ctl_io_o = 16'h4321, ctl_io_oe = 16'hFFFF;
  logic [1:0] ctl_dqs_i;
  logic [15:0] ctl_io_i;
  logic mx_clk = 1'b1, mx_nclk = 1'b0, mx_dqs_o = 1'b1, mx_dqs_oe = 1'b1;
  logic [7:0] mx_io_o = 8'h96, mx_io_oe = 8'hFF;
  logic mx_dqs_i;
  logic [7:0] mx_io_i;
  logic [NP-1:0] pin_clk, pin_nclk, pin_clk_oe, pin_dqs_o, pin_dqs_oe, pin_ncs, pin_ncs_oe;
  logic [NP-1:0] pin_dqs_i = 3'b110;
  logic [NP*8-1:0] pin_io_o, pin_io_oe;
  logic [NP*8-1:0] pin_io_i = 24'hFEDCBA;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmx #(.NUM_PORTS(NP), .NIB_W(NW), .ADDR_W(AW)) i_pinmx (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_err(cfg_err), .ctl_active(ctl_active),
    .mux_en_o(mux_en_o), .sw_time_o(sw_time_o),
    .ctl_clk(ctl_clk), .ctl_nclk(ctl_nclk), .ctl_ncs(ctl_ncs),
    .ctl_dqs_o(ctl_dqs_o), .ctl_dqs_oe(ctl_dqs_oe), .ctl_io_o(ctl_io_o), .ctl_io_oe(ctl_io_oe),
    .ctl_dqs_i(ctl_dqs_i), .ctl_io_i(ctl_io_i),
    .mx_clk(mx_clk), .mx_nclk(mx_nclk), .mx_dqs_o(mx_dqs_o), .mx_dqs_oe(mx_dqs_oe),
    .mx_io_o(mx_io_o), .mx_io_oe(mx_io_oe), .mx_dqs_i(mx_dqs_i), .mx_io_i(mx_io_i),
    .pin_clk(pin_clk), .pin_nclk(pin_nclk), .pin_clk_oe(pin_clk_oe),
    .pin_dqs_o(pin_dqs_o), .pin_dqs_oe(pin_dqs_oe), .pin_dqs_i(pin_dqs_i),
    .pin_ncs(pin_ncs), .pin_ncs_oe(pin_ncs_oe),
    .pin_io_o(pin_io_o), .pin_io_oe(pin_io_oe), .pin_io_i(pin_io_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'h0, d); chk("R1 ctrl reset", d, 32'h0);
    rd(4'h4, d); chk("R1 port0 reset", d, 32'h0301_0111);
    rd(4'h8, d); chk("R1 port1 reset", d, 32'h0705_0333);
    rd(4'hC, d); chk("R1 port2 reset", d, 32'h0301_0111);
    chk("R1 err reset", {31'b0, cfg_err}, 32'h0);
    chk("R1 pins natural", pin_io_o, 32'h0021_4321);
    chk("R1 pin oe", pin_io_oe, 32'h00FF_FFFF);
    chk("R4 clk", {29'b0, pin_clk}, 32'h2);
    chk("R4 nclk", {29'b0, pin_nclk}, 32'h5);
    chk("R4 clk oe", {29'b0, pin_clk_oe}, 32'h7);
    chk("R4 dqs", {29'b0, pin_dqs_o}, 32'h2);
    chk("R4 dqs oe", {29'b0, pin_dqs_oe}, 32'h7);
    chk("R4 ncs", {29'b0, pin_ncs}, 32'h2);
    chk("R6 return lowest port", {16'b0, ctl_io_i}, 32'hDCBA);
    chk("R6 dqs return lowest port", {30'b0, ctl_dqs_i}, 32'h2);
    chk("R7 bus idle", {23'b0, mx_dqs_i, mx_io_i}, 32'h0);

    // R10 one-cycle output latency
    @(negedge clk);
    ctl_io_o = 16'h8765;
    #1 chk("R10 before edge", {24'b0, pin_io_o[7:0]}, 32'h21);
    @(negedge clk);
    chk("R10 after edge", {24'b0, pin_io_o[7:0]}, 32'h65);
    ctl_io_o = 16'h4321;
    settle();

    // R3/R4/R5/R7 table walk over port 1
    for (int i = 0; i < NVEC; i++) begin
      logic [50:0] v;
      v = VEC[i];
      wr(4'h0, {31'b0, v[18]});
      wr(4'h8, v[50:19]);
      settle();
      chk("R3/R7 nibble route", {24'b0, pin_io_o[15:8]}, {24'b0, v[17:10]});
      chk("R5/R7 nibble oe", {24'b0, pin_io_oe[15:8]}, {24'b0, v[9:2]});
      chk("R4 clk route", {31'b0, pin_clk[1]}, {31'b0, v[1]});
      chk("R4 clk oe route", {31'b0, pin_clk_oe[1]}, {31'b0, v[0]});
    end
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h0705_0333);

    // R2 reserved bits, R11 control outputs, R10 unmapped offsets
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R2 port mask", d, 32'h0707_0333);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 ctrl mask", d, 32'h00FF_0001);
    chk("R11 mux out", {31'b0, mux_en_o}, 32'h1);
    wr(4'h0, 32'h00AB_0000);
    settle();
    chk("R11 switch time", {24'b0, sw_time_o}, 32'hAB);
    chk("R11 mux off", {31'b0, mux_en_o}, 32'h0);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0301_0111);
    wr(4'h6, 32'h0);
    wr(4'hE, 32'h0);
    rd(4'h4, d); chk("R10 unaligned ignored", d, 32'h0301_0111);
    rd(4'h8, d); chk("R10 unmapped ignored", d, 32'h0705_0333);
    rd(4'hE, d); chk("R10 unmapped reads zero", d, 32'h0);

    // R6 low nibble wins within a port; duplicates still drive pins
    wr(4'h4, 32'h0101_0000);
    settle();
    chk("R6 low nibble priority", {16'b0, ctl_io_i}, 32'hDCFA);
    chk("R3 duplicate source", {24'b0, pin_io_o[7:0]}, 32'h11);

    // R5 disabled groups
    wr(4'h4, 32'h0);
    wr(4'hC, 32'h0);
    settle();
    chk("R5 return zero", {16'b0, ctl_io_i}, 32'hDC00);
    chk("R5 dqs return zero", {30'b0, ctl_dqs_i}, 32'h2);
    chk("R5 pins zero", {16'b0, pin_io_o[7:0], pin_io_oe[7:0]}, 32'h0);
    chk("R5 ctrl oe low", {29'b0, pin_clk_oe[0], pin_ncs_oe[0], pin_dqs_oe[0]}, 32'h0);
    wr(4'h4, 32'h0301_0111);
    wr(4'hC, 32'h0301_0111);

    // R7/R8 multiplexed mode
    wr(4'h0, 32'h1);
    pin_dqs_i = 3'b101;
    settle();
    chk("R7 ctl inputs quiet", {14'b0, ctl_dqs_i, ctl_io_i}, 32'h0);
    chk("R7 bus data return", {24'b0, mx_io_i}, 32'hBA);
    chk("R7 bus dqs return", {31'b0, mx_dqs_i}, 32'h1);
    chk("R7 bus drives port0", {24'b0, pin_io_o[7:0]}, 32'h96);
    chk("R7 ctrl2 codes dead", {16'b0, pin_io_o[15:8], pin_io_oe[15:8]}, 32'h0);
    chk("R8 ncs per controller", {29'b0, pin_ncs}, 32'h2);
    chk("R8 ncs oe", {29'b0, pin_ncs_oe}, 32'h7);
    wr(4'h0, 32'h0);
    pin_dqs_i = 3'b110;

    // R9 blocked writes and sticky error
    ctl_active = 2'b01;
    wr(4'h4, 32'h0);
    settle();
    rd(4'h4, d); chk("R9 write blocked", d, 32'h0301_0111);
    chk("R9 err set", {31'b0, cfg_err}, 32'h1);
    chk("R9 pins unchanged", {24'b0, pin_io_oe[7:0]}, 32'hFF);
    ctl_active = 2'b10;
    wr(4'h0, 32'h1);
    settle();
    chk("R9 ctrl blocked", {31'b0, mux_en_o}, 32'h0);
    ctl_active = 2'b00;
    wr(4'h4, 32'h0301_0111);
    settle();
    chk("R9 err sticky", {31'b0, cfg_err}, 32'h1);

    done = 1'b1;
    report();
  end

endmodule